// File: doc/BRIEF.md
# Page Write Collector with Self-Timed Busy Window

This block sits behind the bus controller of a small serial nonvolatile memory. During a write transfer it gathers the incoming data bytes into a four-lane page register. Each byte goes to the lane chosen by the low bits of a write-address counter, which is loaded from the word address. When the transfer closes with a stop and at least one byte was received, it issues a single page-wide write to the storage array. The write carries a lane enable mask, so only the lanes that received data are changed.

After the commit, the block raises a busy flag for a fixed number of system clocks. This stands in for the self-timed programming interval. While busy is high, every request from the bus controller is dropped, so the flag can drive acknowledge polling. A single-byte write is simply a page write in which one lane is enabled.

Top module: `pgwr_commit`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, busy_o and arr_we_o are 0.
- R2: A word-address load sets the counter to waddr_i. Each accepted byte is stored in lane (counter mod 4) and advances only the low 2 counter bits. arr_page_o reports counter bits [6:2] and keeps them unchanged across the bytes.
- R3: A fifth or later byte in one transfer wraps into the same page and replaces the byte held in that lane.
- R4: A stop that closes a transfer with at least one byte makes arr_we_o high for exactly one cycle, in the cycle after the stop is sampled. In that cycle, bit i of arr_be_o marks lane i as written, arr_wdata_o[8i+7:8i] holds lane i, and lanes that were not written read as zero.
- R5: A stop with no byte since the last address load, abort or commit produces no array write and leaves busy_o low.
- R6: An abort discards the collected bytes, so a following stop commits nothing.
- R7: busy_o rises in the same cycle as arr_we_o and stays high for exactly WR_CYCLES cycles.
- R8: While busy_o is high, address loads, bytes, stops and aborts have no effect. Bytes sent during that time are not committed later, and the counter keeps its old page and offset.
- R9: A new address load clears every lane collected before it, so those lanes are not enabled at the next commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| waddr_ld_i | input | 1 | Load word address strobe |
| waddr_i | input | 7 | Word address |
| wbyte_vld_i | input | 1 | Data byte strobe |
| wbyte_i | input | 8 | Data byte |
| stop_i | input | 1 | Stop condition strobe |
| abort_i | input | 1 | Transfer abort strobe (repeated start) |
| busy_o | output | 1 | Self-timed write in progress |
| arr_we_o | output | 1 | Array page write pulse |
| arr_page_o | output | 5 | Page index of the array write |
| arr_be_o | output | 4 | Lane enables of the array write |
| arr_wdata_o | output | 32 | Page data, lane i at bits [8i+7:8i] |

## Verification
The hardest state to reach from the ports is a full busy window that is hit by a complete fake transfer: an address load, a byte and a stop, all arriving while the timer runs. This has to be followed by proof that none of it left a trace. The stimulus injects that transfer during the lockout. Once busy falls it sends a bare stop, which must commit nothing. It then sends a single byte with no new address load, and that byte must land at the lane and page left over from the transfer before the lockout. The table-driven part covers the wraps: six-byte transfers that cross the lane boundary twice, and the last page of the address space.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  typedef enum logic [2:0] {
    EV_NONE,
    EV_LOAD,
    EV_BYTE,
    EV_STOP,
    EV_ABORT
  } pgwr_ev_e;
endpackage

// File: rtl/pgwr_addr_ctr.sv
module pgwr_addr_ctr #(
  parameter int ADDR_W = 7,
  parameter int OFF_W  = 2,
  localparam int PAGE_W = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              inc_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [OFF_W-1:0]  off_o
);
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      off_q  <= '0;
    end else if (load_i) begin
      page_q <= addr_i[ADDR_W-1:OFF_W];
      off_q  <= addr_i[OFF_W-1:0];
    end else if (inc_i) begin
      off_q  <= off_q + 1'b1;  // wraps inside the page
    end
  end

  assign page_o = page_q;
  assign off_o  = off_q;

  a_r2_page_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !load_i |=> page_o == $past(page_o));
  a_r2_load_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> {page_o, off_o} == $past(addr_i));
endmodule

// File: rtl/pgwr_page_buf.sv
module pgwr_page_buf #(
  parameter int LANES  = 4,
  parameter int DATA_W = 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    wr_i,
  input  logic [OFF_W-1:0]        off_i,
  input  logic [DATA_W-1:0]       data_i,
  output logic [LANES-1:0]        mask_o,
  output logic [LANES*DATA_W-1:0] data_o
);
  logic [LANES-1:0] mask_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DATA_W-1:0] lane_q;
    logic              hit;
    assign hit = wr_i && (off_i == OFF_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lane_q    <= '0;
        mask_q[g] <= 1'b0;
      end else begin
        if (hit) lane_q <= data_i;
        if (clr_i)    mask_q[g] <= 1'b0;
        else if (hit) mask_q[g] <= 1'b1;
      end
    end

    assign data_o[g*DATA_W +: DATA_W] = mask_q[g] ? lane_q : '0;
  end

  assign mask_o = mask_q;

  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> mask_o == '0);
  a_r4_lane_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !clr_i |=> mask_o[$past(off_i)]);
endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
  parameter int WR_CYCLES = 16,
  localparam int CNT_W = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(WR_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;

  a_r7_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> !busy_o);
endmodule

// File: rtl/pgwr_commit.sv
module pgwr_commit
  import pgwr_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int LANES     = 4,
  parameter int WR_CYCLES = 16,
  localparam int OFF_W  = $clog2(LANES),
  localparam int PAGE_W = ADDR_W - OFF_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    waddr_ld_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic                    wbyte_vld_i,
  input  logic [DATA_W-1:0]       wbyte_i,
  input  logic                    stop_i,
  input  logic                    abort_i,
  output logic                    busy_o,
  output logic                    arr_we_o,
  output logic [PAGE_W-1:0]       arr_page_o,
  output logic [LANES-1:0]        arr_be_o,
  output logic [LANES*DATA_W-1:0] arr_wdata_o
);
  pgwr_ev_e                ev;
  logic                    busy;
  logic                    commit;
  logic [PAGE_W-1:0]       page;
  logic [OFF_W-1:0]        off;
  logic [LANES-1:0]        mask;
  logic [LANES*DATA_W-1:0] pdata;

  // requests are dropped during the busy window; abort outranks stop
  always_comb begin
    ev = EV_NONE;
    if (!busy) begin
      if (abort_i)          ev = EV_ABORT;
      else if (stop_i)      ev = EV_STOP;
      else if (waddr_ld_i)  ev = EV_LOAD;
      else if (wbyte_vld_i) ev = EV_BYTE;
    end
  end

  assign commit = (ev == EV_STOP) && (mask != '0);

  pgwr_addr_ctr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ev == EV_LOAD),
    .addr_i (waddr_i),
    .inc_i  (ev == EV_BYTE),
    .page_o (page),
    .off_o  (off)
  );

  pgwr_page_buf #(.LANES(LANES), .DATA_W(DATA_W)) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ev == EV_ABORT || ev == EV_LOAD || ev == EV_STOP),
    .wr_i   (ev == EV_BYTE),
    .off_i  (off),
    .data_i (wbyte_i),
    .mask_o (mask),
    .data_o (pdata)
  );

  pgwr_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (commit),
    .busy_o  (busy)
  );

  logic                    we_q;
  logic [PAGE_W-1:0]       page_q;
  logic [LANES-1:0]        be_q;
  logic [LANES*DATA_W-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      page_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
    end else begin
      we_q <= commit;
      if (commit) begin
        page_q  <= page;
        be_q    <= mask;
        wdata_q <= pdata;
      end
    end
  end

  assign busy_o      = busy;
  assign arr_we_o    = we_q;
  assign arr_page_o  = page_q;
  assign arr_be_o    = be_q;
  assign arr_wdata_o = wdata_q;

  a_r7_we_opens_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> busy_o && !$past(busy_o));
  a_r4_we_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |=> !arr_we_o);
  a_r5_empty_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !abort_i && !busy_o && mask == '0 |=> !arr_we_o && !busy_o);
  a_r8_busy_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> !arr_we_o);
  a_r4_be_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> arr_be_o != '0);
endmodule

// File: tb/pgwr_commit_tb_top.sv
module pgwr_commit_tb_top;
  localparam int W = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        waddr_ld_i = 1'b0;
  logic [6:0]  waddr_i = '0;
  logic        wbyte_vld_i = 1'b0;
  logic [7:0]  wbyte_i = '0;
  logic        stop_i = 1'b0;
  logic        abort_i = 1'b0;
  logic        busy_o, arr_we_o;
  logic [4:0]  arr_page_o;
  logic [3:0]  arr_be_o;
  logic [31:0] arr_wdata_o;

  int n_run = 0;
  int n_fail = 0;
  int run_len = 0;
  int last_len = 0;
  int we_cnt = 0;

  always #2 clk_i = ~clk_i;

  pgwr_commit #(.WR_CYCLES(W)) dut_i (
    .clk_i, .rst_ni, .waddr_ld_i, .waddr_i, .wbyte_vld_i, .wbyte_i,
    .stop_i, .abort_i, .busy_o, .arr_we_o, .arr_page_o, .arr_be_o, .arr_wdata_o
  );

  // busy run length and write pulses, sampled before each edge
  always @(posedge clk_i) begin
    if (arr_we_o) we_cnt <= we_cnt + 1;
    if (busy_o) run_len <= run_len + 1;
    else begin
      if (run_len != 0) last_len <= run_len;
      run_len <= 0;
    end
  end

  // {addr[6:0], count[3:0], seed[7:0]}
  localparam logic [18:0] VEC [6] = '{
    {7'h00, 4'd1, 8'h11},
    {7'h05, 4'd2, 8'h20},
    {7'h0E, 4'd4, 8'h30},
    {7'h13, 4'd6, 8'h40},
    {7'h7F, 4'd3, 8'h50},
    {7'h2A, 4'd5, 8'hA0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk_i); endtask
  task automatic send_load(input logic [6:0] a);
    waddr_ld_i = 1'b1; waddr_i = a; tick(); waddr_ld_i = 1'b0;
  endtask
  task automatic send_byte(input logic [7:0] d);
    wbyte_vld_i = 1'b1; wbyte_i = d; tick(); wbyte_vld_i = 1'b0;
  endtask
  task automatic send_stop(); stop_i = 1'b1; tick(); stop_i = 1'b0; endtask
  task automatic send_abort(); abort_i = 1'b1; tick(); abort_i = 1'b0; endtask
  task automatic wait_idle();
    while (busy_o) tick();
    tick();
  endtask

  task automatic chk_commit(input string tag, input logic [4:0] pg, input logic [3:0] be, input logic [31:0] d);
    chk(arr_we_o === 1'b1, {tag, " R4 we"}, 32'(arr_we_o), 1);
    chk(busy_o === 1'b1, {tag, " R7 busy with we"}, 32'(busy_o), 1);
    chk(arr_page_o === pg, {tag, " R2 page"}, 32'(arr_page_o), 32'(pg));
    chk(arr_be_o === be, {tag, " R4 be"}, 32'(arr_be_o), 32'(be));
    chk(arr_wdata_o === d, {tag, " R3 data"}, arr_wdata_o, d);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(); tick();
    chk(busy_o === 1'b0 && arr_we_o === 1'b0, "R1 in reset", {busy_o, arr_we_o}, 0);
    rst_ni = 1'b1;
    tick();
    chk(busy_o === 1'b0 && arr_we_o === 1'b0, "R1 after reset", {busy_o, arr_we_o}, 0);

    // table of page writes
    for (int v = 0; v < 6; v++) begin
      logic [6:0]  a;
      logic [3:0]  n;
      logic [7:0]  s;
      logic [3:0]  be;
      logic [31:0] d;
      {a, n, s} = VEC[v];
      be = '0; d = '0;
      send_load(a);
      for (int i = 0; i < int'(n); i++) begin
        int off;
        off = (int'(a) + i) % 4;
        be[off] = 1'b1;
        d[off*8 +: 8] = s + 8'(i);
        send_byte(s + 8'(i));
      end
      send_stop();
      chk_commit($sformatf("vec%0d", v), a[6:2], be, d);
      tick();
      chk(arr_we_o === 1'b0, "R4 we one cycle", 32'(arr_we_o), 0);
      wait_idle();
      chk(last_len == W, "R7 busy length", last_len, W);
    end

    // R5: stop without data
    send_load(7'h10);
    send_stop();
    chk(arr_we_o === 1'b0 && busy_o === 1'b0, "R5 empty stop", {busy_o, arr_we_o}, 0);
    tick();
    chk(busy_o === 1'b0, "R5 still idle", 32'(busy_o), 0);

    // R6: abort drops collected bytes
    send_load(7'h20);
    send_byte(8'h01);
    send_byte(8'h02);
    send_abort();
    send_stop();
    chk(arr_we_o === 1'b0 && busy_o === 1'b0, "R6 abort then stop", {busy_o, arr_we_o}, 0);

    // R9: address load clears earlier lanes
    send_load(7'h31);
    send_byte(8'h77);
    send_load(7'h44);
    send_byte(8'h88);
    send_stop();
    chk_commit("R9", 5'h11, 4'b0001, 32'h0000_0088);
    wait_idle();

    // R8: fake transfer during busy leaves no trace
    send_load(7'h09);
    send_byte(8'h5A);
    send_byte(8'h5B);
    send_stop();
    chk_commit("R8 base", 5'h02, 4'b0110, 32'h005B_5A00);
    begin
      int we0;
      we0 = we_cnt;
      tick();
      send_load(7'h60);
      send_byte(8'hEE);
      send_stop();
      send_abort();
      wait_idle();
      chk(we_cnt - we0 == 1, "R8 no write during busy", we_cnt - we0, 1);
      chk(last_len == W, "R8 R7 busy length unchanged", last_len, W);
    end
    send_stop();
    chk(arr_we_o === 1'b0 && busy_o === 1'b0, "R8 ignored bytes not committed", {busy_o, arr_we_o}, 0);
    send_byte(8'h66);
    send_stop();
    chk_commit("R8 counter kept", 5'h02, 4'b1000, 32'h6600_0000);
    wait_idle();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule